// File: doc/BRIEF.md
# Signed-Digit Shift-and-Add Multiplier

This block multiplies a signed two's complement multiplicand by a multiplier that arrives already recoded as a vector of signed digits. Each digit is -1, 0 or +1. The block walks the digit vector from the least significant position, one position per clock. At a +1 position it adds the multiplicand, shifted to that position, into a double-width accumulator. At a -1 position it adds the two's complement of the same shifted value. At a zero position it adds nothing and only moves the shift on.

A recoder upstream normally supplies a canonical vector, in which no two neighbouring digits are both nonzero. The datapath itself accepts any digit pattern and returns the exact signed value of that pattern times the multiplicand. A caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `product`, which stays put until the next accepted start.

Top module: `csd_shift_add_mul`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen while `busy` is 0 is accepted: `busy` is 1 from the next cycle on, and `done` pulses exactly N clock edges after the accepting edge, one edge per digit position (N = 12 by default).
- R3: When `done` is 1, `product` holds the 2N-bit two's complement value of the signed `mcand` times the signed value of the digit vector. No digit vector of N digits can overflow it; for example 10 times 11 gives 110.
- R4: Digit i takes bits [2i+1:2i] of `digits` and carries weight 2^i. The code 2'b10 means +1, 2'b11 means -1, and both 2'b00 and 2'b01 mean zero.
- R5: A zero digit position leaves the accumulator, and therefore `product`, unchanged during its cycle.
- R6: While `busy` is 1, `start` has no effect. The operation in progress finishes on time and with its own result.
- R7: `done` is high for a single cycle. While idle with no `start`, `product` does not change.
- R8: Changes to `mcand` and `digits` after the accepting edge do not affect the result of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; taken only while idle |
| mcand | input | N | Multiplicand, two's complement |
| digits | input | 2N | Multiplier as N signed digits, two bits each |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
The checker watches the control behaviour on every cycle. It checks that an accepted start raises `busy`, and that `busy` stays up until the last digit position. It checks that `done` lasts one cycle and arrives after exactly N busy cycles. It also checks that `product` stays still on zero-digit steps and while the block is idle. The numeric result cannot be checked as a cycle property, so the bench's scenarios cover it: small hand cases, canonical vectors such as 287 and 345, extreme non-canonical vectors, the two "zero" codes, random operands, and the ignored restart and operand changes in mid-operation.

// File: rtl/csd_mul_pkg.sv
package csd_mul_pkg;

  // Digit code: bit 1 = nonzero, bit 0 = negative (only meaningful when nonzero)
  function automatic logic digit_active(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic digit_negative(input logic [1:0] code);
    return code[1] & code[0];
  endfunction

endpackage

// File: rtl/csd_mul_ctrl.sv
module csd_mul_ctrl #(
  parameter int DIGITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIGITS - 1);

  logic [CW-1:0] pos_q;

  assign load      = start & ~busy;
  assign step      = busy;
  assign last_step = busy & (pos_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pos_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        pos_q <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos_q <= pos_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/csd_digit_shreg.sv
module csd_digit_shreg #(
  parameter int DIGITS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic [2*DIGITS-1:0]   digits_in,
  output logic [1:0]            cur_code
);
  localparam int DW = 2 * DIGITS;

  logic [DW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= digits_in;
    else if (step) code_q <= {2'b00, code_q[DW-1:2]};
  end

  assign cur_code = code_q[1:0];
endmodule

// File: rtl/csd_addend_gen.sv
module csd_addend_gen #(
  parameter int N = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [N-1:0]    mcand,
  input  logic            negate_en,
  output logic [2*N-1:0]  addend
);
  localparam int PW = 2 * N;

  function automatic logic [PW-1:0] twos_neg(input logic [PW-1:0] x);
    return ~x + PW'(1);
  endfunction

  function automatic logic [PW-1:0] sign_ext(input logic [N-1:0] x);
    return {{(PW-N){x[N-1]}}, x};
  endfunction

  logic [PW-1:0] shifted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shifted_q <= '0;
    else if (load) shifted_q <= sign_ext(mcand);
    else if (step) shifted_q <= {shifted_q[PW-2:0], 1'b0};
  end

  assign addend = negate_en ? twos_neg(shifted_q) : shifted_q;
endmodule

// File: rtl/csd_accum.sv
module csd_accum #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add_en,
  input  logic [PW-1:0] addend,
  output logic [PW-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (add_en) acc <= acc + addend;
  end
endmodule

// File: rtl/csd_shift_add_mul.sv
module csd_shift_add_mul #(
  parameter int N = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N-1:0]     mcand,
  input  logic [2*N-1:0]   digits,
  output logic             busy,
  output logic             done,
  output logic [2*N-1:0]   product
);
  import csd_mul_pkg::*;

  localparam int DIGITS = N;
  localparam int PW     = 2 * N;

  // named internal events
  logic          load;
  logic          step;
  logic          last_step;
  logic [1:0]    cur_code;
  logic          add_fire;
  logic          sub_fire;
  logic [PW-1:0] addend;
  logic [PW-1:0] acc;

  csd_mul_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .last_step(last_step),
    .busy(busy), .done(done)
  );

  csd_digit_shreg #(.DIGITS(DIGITS)) u_digits (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .digits_in(digits), .cur_code(cur_code)
  );

  assign add_fire = step & digit_active(cur_code);
  assign sub_fire = step & digit_negative(cur_code);

  csd_addend_gen #(.N(N)) u_addend (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mcand(mcand), .negate_en(sub_fire), .addend(addend)
  );

  csd_accum #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(load), .add_en(add_fire),
    .addend(addend), .acc(acc)
  );

  assign product = acc;
endmodule

// File: rtl/csd_mul_checker.sv
module csd_mul_checker #(
  parameter int N = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic           step,
  input logic           add_fire,
  input logic           sub_fire,
  input logic           last_step
);
  int busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cycles <= 0;
    else if (start && !busy) busy_cycles <= 0;
    else if (busy)           busy_cycles <= busy_cycles + 1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && product == '0));

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cycles == N));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  a_r5_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !add_fire) |=> $stable(product));

  a_r4_neg_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fire |-> (busy && add_fire));
endmodule

bind csd_shift_add_mul csd_mul_checker #(.N(N)) u_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .product(product), .step(step), .add_fire(add_fire),
  .sub_fire(sub_fire), .last_step(last_step)
);

// File: tb/test_csd_shift_add_mul.sv
module test_csd_shift_add_mul;
  localparam int  N     = 12;
  localparam int  PW    = 2 * N;
  localparam time CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  mcand = '0;
  logic [PW-1:0] digits = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  csd_shift_add_mul #(.N(N)) i_csd_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .digits(digits), .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench's own reading of the digit codes (R4)
  function automatic longint vec_value(input logic [PW-1:0] d);
    longint s = 0;
    for (int i = 0; i < N; i++) begin
      if (d[2*i+1] && d[2*i]) s -= (longint'(1) <<< i);
      else if (d[2*i+1])      s += (longint'(1) <<< i);
    end
    return s;
  endfunction

  // Non-adjacent recoding of a signed integer
  function automatic logic [PW-1:0] to_csd(input int v);
    logic [PW-1:0] r = '0;
    int x = v;
    for (int i = 0; i < N; i++) begin
      if (x % 2 != 0) begin
        if (((x % 4) + 4) % 4 == 1) begin r[2*i +: 2] = 2'b10; x = x - 1; end
        else                        begin r[2*i +: 2] = 2'b11; x = x + 1; end
      end
      x = x / 2;
    end
    return r;
  endfunction

  function automatic longint sproduct();
    return longint'($signed(product));
  endfunction

  // Start one multiplication, wait for done, return latency and result
  task automatic run_mul(input logic [N-1:0] a, input logic [PW-1:0] d,
                         output int lat, output longint res);
    @(negedge clk);
    mcand = a; digits = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = sproduct();
  endtask

  task automatic mul_and_check(input int a, input logic [PW-1:0] d, input string req);
    int lat; longint res, exp;
    exp = longint'(a) * vec_value(d);
    run_mul(N'(a), d, lat, res);
    // done appears N edges after the accepting edge: N+1 negedges counted
    check(lat == N + 1, "R2", "latency", lat, N + 1);
    check(res == exp, req, "product", res, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(product == '0, "R1", "product after reset", sproduct(), 0);
  endtask

  task automatic t_hand_cases();
    mul_and_check(10, to_csd(11), "R3");     // 10 * 11 = 110
    mul_and_check(7, to_csd(287), "R3");
    mul_and_check(-5, to_csd(345), "R3");
    mul_and_check(-2048, to_csd(-2048), "R3");
    mul_and_check(2047, to_csd(2047), "R3");
    mul_and_check(0, to_csd(1365), "R3");
  endtask

  task automatic t_encoding();
    logic [PW-1:0] d;
    mul_and_check(123, {N{2'b01}}, "R4");     // 01 codes act as zero
    mul_and_check(123, {N{2'b00}}, "R5");     // all zero digits
    d = '0; d[11:10] = 2'b10; d[1:0] = 2'b11; // +32 and -1
    mul_and_check(3, d, "R4");
    mul_and_check(-2048, {N{2'b10}}, "R3");   // non-canonical extreme
    mul_and_check(-2048, {N{2'b11}}, "R3");
    mul_and_check(-1, {N{2'b10}}, "R4");
  endtask

  task automatic t_restart_ignored();
    int lat; longint exp;
    exp = longint'(37) * 287;
    @(negedge clk);
    mcand = N'(37); digits = to_csd(287); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    mcand = N'(-99); digits = to_csd(-500); start = 1'b1;
    @(negedge clk);
    lat++; start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == N + 1, "R6", "latency with restart", lat, N + 1);
    check(sproduct() == exp, "R6", "product with restart", sproduct(), exp);
    @(negedge clk);
    check(busy == 1'b0, "R6", "idle after run", busy, 0);
  endtask

  task automatic t_operand_change();
    int lat; longint exp;
    exp = longint'(-321) * 345;
    @(negedge clk);
    mcand = N'(-321); digits = to_csd(345); start = 1'b1;
    @(negedge clk);
    start = 1'b0; mcand = N'(555); digits = {N{2'b10}}; lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(sproduct() == exp, "R8", "product after operand change", sproduct(), exp);
  endtask

  task automatic t_hold();
    longint held;
    mul_and_check(-77, to_csd(-1000), "R3");
    held = sproduct();
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", done, 0);
    mcand = N'(1); digits = {N{2'b10}};
    repeat (4) @(negedge clk);
    check(sproduct() == held, "R7", "product held idle", sproduct(), held);
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) begin
      int a = int'($urandom_range(4095)) - 2048;
      int v = int'($urandom_range(4094)) - 2047;
      mul_and_check(a, to_csd(v), "R3");
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hand_cases();
    t_encoding();
    t_restart_ignored();
    t_operand_change();
    t_hold();
    t_random();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule